// File: doc/BRIEF.md
# 8x8 Bit-Matrix Multiply Unit

This unit views each 64-bit operand as an 8x8 bit matrix of eight row bytes. Row r is bits 8r+7..8r and element (r,c) is bit 8r+c. It can return the transpose of the first operand. It can also form one of three matrix products of the first operand with the second.

The three products differ only in how each row byte of the first operand is combined with each column of the second. The XOR product reduces that overlap by parity and then adds an 8-bit constant vector, which gives a GF(2) affine transform. The OR product marks an element when any bit overlaps. The AND product marks an element only when all eight bits overlap.

One operation is accepted per cycle. The result appears one cycle later together with a valid flag.

Top module: `bmm_unit`

## Requirements
- R1: A synchronous active-high reset clears `res_valid` and `res_data` at the next clock edge.
- R2: `res_valid` is high exactly in the cycle after a cycle where `in_valid` was high, and low otherwise; `res_data` holds its value when `in_valid` is low.
- R3: Operation code 2'b00 (flip) returns the transpose: result bit 8r+c equals bit 8c+r of `op_a`.
- R4: Flip ignores `op_b` and `imm`; changing them does not change the flip result.
- R5: Code 2'b01 (xor product): result bit 8r+c = imm[c] XOR parity(row r of `op_a` AND column c of `op_b`). Column c of `op_b` is the byte of bits 8k+c for k=0..7, with bit k of that byte taken from row k.
- R6: With imm = 8'hFF the xor product gives the inverted parity of each row/column overlap. With imm = 8'h00 it gives the plain GF(2) product, so an identity `op_b` returns `op_a`.
- R7: Code 2'b10 (or product): result bit 8r+c is 1 when row r of `op_a` AND column c of `op_b` is nonzero.
- R8: Code 2'b11 (and product): result bit 8r+c is 1 only when row r of `op_a` AND column c of `op_b` equals 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| op_sel | input | 2 | 00 flip, 01 xor product, 10 or product, 11 and product |
| op_a | input | 64 | First matrix (rows) |
| op_b | input | 64 | Second matrix (columns taken) |
| imm | input | 8 | Affine constant for the xor product, bit c applies to column c |
| res_valid | output | 1 | Result valid, one cycle after request |
| res_data | output | 64 | Result matrix |

## Verification
The bench uses asymmetric matrices with a single bit set, so a design that swapped rows and columns, or indexed the transpose the wrong way, places the bit at the mirrored position. Identity and all-ones operands are used to tell parity apart from OR reduction. A design that took the AND product as "any bit" would report ones where only partial overlap exists. Flip is repeated with changed `op_b` and `imm` to catch leakage of the second operand. The xor product is run with imm at 00, FF and an odd pattern, which exposes an affine constant applied per row instead of per column.

// File: rtl/bmm_pkg.sv
package bmm_pkg;
  typedef enum logic [1:0] {
    OP_FLIP = 2'b00,
    OP_XPRD = 2'b01,
    OP_OPRD = 2'b10,
    OP_APRD = 2'b11
  } bmm_op_e;
endpackage

// File: rtl/bmm_transpose.sv
module bmm_transpose #(
  parameter int DIM = 8,
  localparam int W = DIM * DIM
) (
  input  logic [W-1:0] mat_in,
  output logic [W-1:0] mat_out
);
  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      assign mat_out[r*DIM + c] = mat_in[c*DIM + r];
    end
  end
endmodule

// File: rtl/bmm_cell.sv
module bmm_cell #(
  parameter int DIM = 8
) (
  input  logic [DIM-1:0] row_v,
  input  logic [DIM-1:0] col_v,
  output logic           par_o,
  output logic           any_o,
  output logic           all_o
);
  logic [DIM-1:0] ov;
  assign ov    = row_v & col_v;
  assign par_o = ^ov;
  assign any_o = |ov;
  assign all_o = &ov;
endmodule

// File: rtl/bmm_unit.sv
module bmm_unit #(
  parameter int DIM = 8,
  localparam int W = DIM * DIM
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [1:0]     op_sel,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic [DIM-1:0] imm,
  output logic           res_valid,
  output logic [W-1:0]   res_data
);
  import bmm_pkg::*;

  logic [W-1:0] a_t, b_t;
  logic [W-1:0] par_m, any_m, all_m;
  logic [W-1:0] nxt;

  bmm_transpose #(.DIM(DIM)) u_ta (.mat_in(op_a), .mat_out(a_t));
  bmm_transpose #(.DIM(DIM)) u_tb (.mat_in(op_b), .mat_out(b_t));

  for (genvar r = 0; r < DIM; r++) begin : g_r
    for (genvar c = 0; c < DIM; c++) begin : g_c
      bmm_cell #(.DIM(DIM)) u_cell (
        .row_v(op_a[r*DIM +: DIM]),
        .col_v(b_t[c*DIM +: DIM]),
        .par_o(par_m[r*DIM + c]),
        .any_o(any_m[r*DIM + c]),
        .all_o(all_m[r*DIM + c])
      );
    end
  end

  always_comb begin
    unique case (bmm_op_e'(op_sel))
      OP_FLIP: nxt = a_t;
      OP_XPRD: nxt = par_m ^ {DIM{imm}};
      OP_OPRD: nxt = any_m;
      default: nxt = all_m;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res_data <= nxt;
    end
  end
endmodule

// File: rtl/bmm_unit_chk.sv
module bmm_unit_chk #(
  parameter int DIM = 8,
  localparam int W = DIM * DIM
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [1:0]     op_sel,
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic [DIM-1:0] imm,
  input logic           res_valid,
  input logic [W-1:0]   res_data
);
  p_reset_clears_r1: assert property (@(posedge clk) rst |=> (!res_valid && res_data == '0));
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst) in_valid |=> res_valid);
  p_valid_drops_r2: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !res_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(res_data));
  p_flip_diag_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b00) |=> (res_data[0] == $past(op_a[0]) && res_data[W-1] == $past(op_a[W-1])));
  p_or_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b10 && op_a == '0) |=> res_data == '0);
  p_and_ones_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b11 && op_a == '1 && op_b == '1) |=> res_data == '1);
endmodule

bind bmm_unit bmm_unit_chk #(.DIM(DIM)) u_chk (.*);

// File: tb/bmm_unit_tb.sv
module bmm_unit_tb;
  logic        clk = 0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  op_sel;
  logic [63:0] op_a, op_b;
  logic [7:0]  imm;
  logic        res_valid;
  logic [63:0] res_data;

  int checks = 0, errors = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  always #10 clk = ~clk;

  bmm_unit u_dut (.*);

  function automatic logic [63:0] ref_op(logic [1:0] s, logic [63:0] a, logic [63:0] b, logic [7:0] k);
    logic [63:0] r;
    logic [7:0] row, col, ov;
    r = '0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        row = a[i*8 +: 8];
        for (int m = 0; m < 8; m++) col[m] = b[m*8 + j];
        ov = row & col;
        case (s)
          2'b00: r[i*8+j] = a[j*8+i];
          2'b01: r[i*8+j] = k[j] ^ (^ov);
          2'b10: r[i*8+j] = |ov;
          default: r[i*8+j] = &ov;
        endcase
      end
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic drive(string tag, logic [1:0] s, logic [63:0] a, logic [63:0] b, logic [7:0] k, logic [63:0] exp);
    @(negedge clk);
    in_valid = 1; op_sel = s; op_a = a; op_b = b; imm = k;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic op(string tag, logic [1:0] s, logic [63:0] a, logic [63:0] b, logic [7:0] k);
    drive(tag, s, a, b, k, ref_op(s, a, b, k));
  endtask

  // monitor: checks valid timing (R2) and compares against queue
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (res_valid) begin
        if (exp_q.size() == 0) check("R2 unexpected valid", 64'd1, 64'd0);
        else check(tag_q.pop_front(), res_data, exp_q.pop_front());
      end
    end
  end

  localparam logic [63:0] IDENT = 64'h8040201008040201;

  initial begin
    rst = 1; in_valid = 0; op_sel = 0; op_a = 0; op_b = 0; imm = 0;
    repeat (2) @(negedge clk);
    check("R1 valid", {63'd0, res_valid}, 64'd0);
    check("R1 data", res_data, 64'd0);
    rst = 0;
    // R3 transpose, asymmetric single bit: (r=1,c=5) bit 13 -> bit 41
    drive("R3 single", 2'b00, 64'h0000_0000_0000_2000, 64'h0, 8'h0, 64'h0000_0200_0000_0000);
    op("R3 pattern", 2'b00, 64'h0123_4567_89AB_CDEF, 64'h0, 8'h0);
    // R4 flip ignores op_b and imm
    op("R4 ignore b", 2'b00, 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_DEAD_BEEF, 8'hA5);
    // R2 hold: no request, data stays
    repeat (2) @(negedge clk);
    check("R2 hold", res_data, ref_op(2'b00, 64'h0123_4567_89AB_CDEF, 0, 0));
    check("R2 idle valid", {63'd0, res_valid}, 64'd0);
    // R6 identity with imm 00 returns op_a
    drive("R6 ident", 2'b01, 64'h1122_3344_5566_7788, IDENT, 8'h00, 64'h1122_3344_5566_7788);
    drive("R6 ff", 2'b01, 64'h1122_3344_5566_7788, IDENT, 8'hFF, ~64'h1122_3344_5566_7788);
    // R5 odd imm, all-ones: parity of 8 bits = 0 -> each row = imm
    drive("R5 ones", 2'b01, '1, '1, 8'h35, 64'h3535_3535_3535_3535);
    op("R5 mixed", 2'b01, 64'hDEAD_BEEF_0BAD_F00D, 64'h0F1E_2D3C_4B5A_6978, 8'h96);
    // R7
    drive("R7 ones", 2'b10, '1, '1, 8'h0, '1);
    drive("R7 ident", 2'b10, 64'h00FF_0000_0000_0001, IDENT, 8'h0, 64'h00FF_0000_0000_0001);
    op("R7 mixed", 2'b10, 64'h0000_8000_0100_0000, 64'h0102_0408_1020_4080, 8'h0);
    // R8
    drive("R8 ones", 2'b11, '1, '1, 8'h0, '1);
    drive("R8 partial", 2'b11, 64'h7F7F_7F7F_7F7F_7F7F, '1, 8'h0, '0);
    drive("R8 row", 2'b11, 64'h0000_0000_0000_00FF, '1, 8'h0, 64'h0000_0000_0000_00FF);
    // back to back for R2
    @(negedge clk);
    in_valid = 1; op_sel = 2'b10; op_a = '1; op_b = '1; imm = 0;
    exp_q.push_back('1); tag_q.push_back("R2 b2b first");
    @(negedge clk);
    op_sel = 2'b11; op_a = 0;
    exp_q.push_back('0); tag_q.push_back("R2 b2b second");
    @(negedge clk);
    in_valid = 0;
    repeat (3) @(negedge clk);
    check("R2 queue drained", 64'(exp_q.size()), 64'd0);
    // R1 reset mid-run
    rst = 1;
    @(negedge clk);
    check("R1 reset again", res_data, 64'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R2 got 0 exp 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule